// File: doc/BRIEF.md
# GPIO event and wake logic

This block manages sixteen general-purpose pins for a serial audio/modem link endpoint. Each pin can be set as an input or an output. Output pins take their values from a 16-bit word carried in the outgoing status/control slot (slot 12). Input pins pass through a two-flop synchronizer. Each input then has a selectable active level, an optional sticky latch, and a mask. The mask decides whether an event on that pin raises the interrupt flag and a wake request.

Software reaches the configuration through a small register port. A write takes effect on the next clock edge. A read is combinational. The incoming slot 12 word carries the pin status in its upper sixteen bits and the interrupt flag in bit 0. A wake request is a one-cycle pulse issued when a masked input pin becomes active.

Register addresses: 0 direction (1 = input, 0 = output), 1 active level (1 = high active, 0 = low active), 2 sticky enable, 3 event mask, 4 status (writing 0 to a bit clears its latch), 5 latched output word (read only). Any other address reads as 0.

Top module: `gpio_event_wake`

## Requirements
- R1: After reset, the direction register reads FFFFh (all pins input) and the active-level register reads FFFFh. The sticky and event mask registers read 0000h. The incoming slot word is 00000h and no pin output enable is set.
- R2: A direction bit of 0 makes its pin an output: `pin_oe_o` is 1 and `pin_o` carries the matching bit of the latched output word. A direction bit of 1 makes its pin an input: `pin_oe_o` and `pin_o` are 0.
- R3: When `out_slot_vld_i` is high on a clock edge, the block stores bits 19:4 of `out_slot_i` as the output word, with bit 19 going to pin 15. The stored word holds while `out_slot_vld_i` is low and reads back at address 5.
- R4: A change on an input pin reaches the status after exactly two clock edges, through the two-flop synchronizer.
- R5: A non-sticky input reports its live active state. When the active-level bit is 1, a high pin is active. When it is 0, a low pin is active. A changed active level applies to the next status.
- R6: When a pin's sticky bit is set, an active event sets that pin's status one edge later. The status then stays set after the pin goes inactive.
- R7: Writing 0 to a status bit clears its latch. Writing 1 has no effect. If the pin is still active in the cycle of the clearing write, the bit stays set.
- R8: The incoming slot word holds the pin status in bits 19:4 (pin 15 at bit 19), zeros in bits 3:1, and the interrupt flag in bit 0. The interrupt flag is the OR of all status bits whose mask bit is 1.
- R9: `wake_o` pulses high for exactly one cycle, three edges after a masked input pin goes from inactive to active. An unmasked pin produces neither a wake pulse nor an interrupt flag.
- R10: A pin set as an output reports status 0 and raises no event, whatever level appears on `pin_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| out_slot_i | input | 20 | Outgoing slot 12 word |
| out_slot_vld_i | input | 1 | Outgoing slot word valid |
| in_slot_o | output | 20 | Incoming slot 12 word: status and interrupt flag |
| pin_i | input | 16 | Pin input levels (asynchronous) |
| pin_o | output | 16 | Pin output values |
| pin_oe_o | output | 16 | Pin output enables |
| wake_o | output | 1 | Wake request pulse |

## Verification
The assertions assume that a written register value settles within one edge. They also assume that `out_slot_vld_i` and the register strobe are synchronous to `clk_i`. Only `pin_i` may change without regard to the clock. The stimulus drives every input at the falling edge. It keeps register writes to single-cycle strobes. It holds each pin level for at least three edges before it checks a result, so the synchronizer and edge detector see each transition exactly once.

// File: rtl/gpio_ev_pkg.sv
package gpio_ev_pkg;
  typedef enum logic [2:0] {
    REG_DIR    = 3'd0,
    REG_POL    = 3'd1,
    REG_STICKY = 3'd2,
    REG_WMASK  = 3'd3,
    REG_STAT   = 3'd4,
    REG_OUTW   = 3'd5
  } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_ev_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [2:0]   addr_i,
  input  logic [N-1:0] wdata_i,
  input  logic [N-1:0] status_i,
  input  logic [N-1:0] out_word_i,
  output logic [N-1:0] dir_o,
  output logic [N-1:0] pol_o,
  output logic [N-1:0] sticky_o,
  output logic [N-1:0] wmask_o,
  output logic [N-1:0] clr_o,
  output logic [N-1:0] rdata_o
);
  logic [N-1:0] dir_q, pol_q, sticky_q, wmask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q    <= '1;
      pol_q    <= '1;
      sticky_q <= '0;
      wmask_q  <= '0;
    end else if (we_i) begin
      case (addr_i)
        REG_DIR:    dir_q    <= wdata_i;
        REG_POL:    pol_q    <= wdata_i;
        REG_STICKY: sticky_q <= wdata_i;
        REG_WMASK:  wmask_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  // zero bits in a status write clear latches
  assign clr_o = (we_i && addr_i == REG_STAT) ? ~wdata_i : '0;

  always_comb begin
    case (addr_i)
      REG_DIR:    rdata_o = dir_q;
      REG_POL:    rdata_o = pol_q;
      REG_STICKY: rdata_o = sticky_q;
      REG_WMASK:  rdata_o = wmask_q;
      REG_STAT:   rdata_o = status_i;
      REG_OUTW:   rdata_o = out_word_i;
      default:    rdata_o = '0;
    endcase
  end

  assign dir_o    = dir_q;
  assign pol_o    = pol_q;
  assign sticky_o = sticky_q;
  assign wmask_o  = wmask_q;
endmodule

// File: rtl/gpio_event.sv
module gpio_event #(
  parameter int unsigned N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_s_i,
  input  logic [N-1:0] dir_i,
  input  logic [N-1:0] pol_i,
  input  logic [N-1:0] sticky_i,
  input  logic [N-1:0] wmask_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] status_o,
  output logic         irq_o,
  output logic         wake_o
);
  logic [N-1:0] act, act_q, rise, latch_q;
  logic         wake_q;

  // active state only for input pins
  assign act  = dir_i & ~(pin_s_i ^ pol_i);
  assign rise = act & ~act_q;

  for (genvar i = 0; i < N; i++) begin : g_pin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) latch_q[i] <= 1'b0;
      else if (!sticky_i[i] || !dir_i[i]) latch_q[i] <= 1'b0;
      else latch_q[i] <= act[i] | (latch_q[i] & ~clr_i[i]);
    end
    assign status_o[i] = sticky_i[i] ? latch_q[i] : act[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= '0;
      wake_q <= 1'b0;
    end else begin
      act_q  <= act;
      wake_q <= |(rise & wmask_i);
    end
  end

  assign irq_o  = |(status_o & wmask_i);
  assign wake_o = wake_q;
endmodule

// File: rtl/gpio_slot_io.sv
module gpio_slot_io #(
  parameter int unsigned N      = 16,
  parameter int unsigned SLOT_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      slot_field_i,
  input  logic              slot_vld_i,
  input  logic [N-1:0]      dir_i,
  input  logic [N-1:0]      status_i,
  input  logic              irq_i,
  output logic [N-1:0]      out_word_o,
  output logic [N-1:0]      pin_o,
  output logic [N-1:0]      pin_oe_o,
  output logic [SLOT_W-1:0] in_slot_o
);
  localparam int unsigned PadW = SLOT_W - N - 1;

  logic [N-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_q <= '0;
    else if (slot_vld_i) word_q <= slot_field_i;
  end

  assign out_word_o = word_q;
  assign pin_oe_o   = ~dir_i;
  assign pin_o      = word_q & ~dir_i;
  assign in_slot_o  = {status_i, {PadW{1'b0}}, irq_i};
endmodule

// File: rtl/gpio_event_wake.sv
module gpio_event_wake #(
  parameter int unsigned N_PINS = 16,
  parameter int unsigned SLOT_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [N_PINS-1:0] reg_wdata_i,
  output logic [N_PINS-1:0] reg_rdata_o,
  input  logic [SLOT_W-1:0] out_slot_i,
  input  logic              out_slot_vld_i,
  output logic [SLOT_W-1:0] in_slot_o,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] pin_o,
  output logic [N_PINS-1:0] pin_oe_o,
  output logic              wake_o
);
  localparam int unsigned LoW = SLOT_W - N_PINS;

  logic [N_PINS-1:0] pin_s, dir_q, pol_q, sticky_q, wmask_q, clr, status, out_word;
  logic              irq;
  logic              unused_vendor;

  assign unused_vendor = ^out_slot_i[LoW-1:0];

  gpio_sync #(.W(N_PINS)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(pin_s)
  );

  gpio_regs #(.N(N_PINS)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .status_i(status), .out_word_i(out_word),
    .dir_o(dir_q), .pol_o(pol_q), .sticky_o(sticky_q), .wmask_o(wmask_q),
    .clr_o(clr), .rdata_o(reg_rdata_o)
  );

  gpio_event #(.N(N_PINS)) u_event (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_s_i(pin_s), .dir_i(dir_q),
    .pol_i(pol_q), .sticky_i(sticky_q), .wmask_i(wmask_q), .clr_i(clr),
    .status_o(status), .irq_o(irq), .wake_o(wake_o)
  );

  gpio_slot_io #(.N(N_PINS), .SLOT_W(SLOT_W)) u_slot (
    .clk_i(clk_i), .rst_ni(rst_ni), .slot_field_i(out_slot_i[SLOT_W-1:LoW]),
    .slot_vld_i(out_slot_vld_i), .dir_i(dir_q), .status_i(status), .irq_i(irq),
    .out_word_o(out_word), .pin_o(pin_o), .pin_oe_o(pin_oe_o), .in_slot_o(in_slot_o)
  );
endmodule

// File: rtl/gpio_event_wake_chk.sv
module gpio_event_wake_chk #(
  parameter int unsigned N_PINS = 16,
  parameter int unsigned SLOT_W = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [2:0]        reg_addr_i,
  input logic [SLOT_W-1:0] out_slot_i,
  input logic              out_slot_vld_i,
  input logic [SLOT_W-1:0] in_slot_o,
  input logic [N_PINS-1:0] pin_oe_o,
  input logic              wake_o,
  input logic [N_PINS-1:0] out_word,
  input logic [N_PINS-1:0] dir_q,
  input logic [N_PINS-1:0] sticky_q,
  input logic [N_PINS-1:0] wmask_q
);
  localparam int unsigned LoW = SLOT_W - N_PINS;

  logic [N_PINS-1:0] stat;
  logic              cfg_wr;
  assign stat   = in_slot_o[SLOT_W-1:LoW];
  assign cfg_wr = reg_we_i && (reg_addr_i == 3'd0 || reg_addr_i == 3'd2 || reg_addr_i == 3'd4);

  a_r3_word_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_slot_vld_i |=> out_word == $past(out_slot_i[SLOT_W-1:LoW]));

  a_r3_word_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_slot_vld_i |=> $stable(out_word));

  a_r6_sticky_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_wr |=> ((stat & $past(stat & sticky_q & dir_q)) == $past(stat & sticky_q & dir_q)));

  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);

  a_r9_wake_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_o) |-> $past(wmask_q) != '0);

  a_r10_out_no_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat & pin_oe_o) == '0);
endmodule

bind gpio_event_wake gpio_event_wake_chk #(.N_PINS(N_PINS), .SLOT_W(SLOT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .out_slot_i(out_slot_i), .out_slot_vld_i(out_slot_vld_i), .in_slot_o(in_slot_o),
  .pin_oe_o(pin_oe_o), .wake_o(wake_o), .out_word(out_word), .dir_q(dir_q),
  .sticky_q(sticky_q), .wmask_q(wmask_q)
);

// File: tb/gpio_event_wake_test.sv
module gpio_event_wake_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [19:0] oslot = '0;
  logic        ovld = 1'b0;
  logic [19:0] islot;
  logic [15:0] pin = '0;
  logic [15:0] pout, poe;
  logic        wake;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_event_wake uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .out_slot_i(oslot),
    .out_slot_vld_i(ovld), .in_slot_o(islot), .pin_i(pin), .pin_o(pout),
    .pin_oe_o(poe), .wake_o(wake)
  );

  typedef struct {
    int          sel;
    logic [19:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];
  event  mon_ev;

  // monitor: pop expectations and compare with the selected output
  initial begin
    forever begin
      @(mon_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [19:0] act;
        it = sb_q.pop_front();
        case (it.sel)
          0: act = {4'h0, rdata};
          1: act = islot;
          2: act = {4'h0, pout};
          3: act = {4'h0, poe};
          default: act = {19'h0, wake};
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %05h expected %05h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expect_val(input int sel, input logic [19:0] exp, input string tag);
    item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    ->mon_ev;
    #1;
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
    addr = a;
    #1;
    expect_val(0, {4'h0, exp}, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    ticks(2);
    rst_n = 1'b1;
    ticks(1);
    // R1 reset state
    rd(3'd0, 16'hFFFF, "R1 dir reset");
    rd(3'd1, 16'hFFFF, "R1 pol reset");
    rd(3'd2, 16'h0000, "R1 sticky reset");
    rd(3'd3, 16'h0000, "R1 mask reset");
    expect_val(1, 20'h00000, "R1 in slot reset");
    expect_val(3, 20'h00000, "R1 oe reset");

    // R2 R3 outputs from slot word
    wr(3'd0, 16'h00FF);
    oslot = {16'hA5C3, 4'hF}; ovld = 1'b1;
    ticks(1);
    ovld = 1'b0; oslot = {16'h1234, 4'h0};
    ticks(1);
    expect_val(2, 20'h0A500, "R2 pin_o");
    expect_val(3, 20'h0FF00, "R2 pin_oe");
    rd(3'd5, 16'hA5C3, "R3 word hold without valid");

    // R4 R5 synchronizer and polarity
    pin = 16'h0001;
    ticks(1);
    expect_val(1, 20'h00000, "R4 not yet after one edge");
    ticks(1);
    expect_val(1, 20'h00010, "R4 R5 high active after two edges");
    wr(3'd1, 16'hFFFE);
    expect_val(1, 20'h00000, "R5 low active sees high as idle");
    pin = 16'h0000;
    ticks(2);
    expect_val(1, 20'h00010, "R5 low active live");
    wr(3'd1, 16'hFFFF);
    expect_val(1, 20'h00000, "R5 back to high active");

    // R10 output pin ignores input
    pin = 16'h0100;
    ticks(3);
    expect_val(1, 20'h00000, "R10 output pin status");
    expect_val(4, 20'h00000, "R10 output pin no wake");
    pin = 16'h0000;

    // R6 R7 sticky latch and clear
    wr(3'd2, 16'h0002);
    pin = 16'h0002;
    ticks(3);
    expect_val(1, 20'h00020, "R6 sticky set");
    pin = 16'h0000;
    ticks(3);
    expect_val(1, 20'h00020, "R6 sticky held");
    wr(3'd4, 16'hFFFF);
    expect_val(1, 20'h00020, "R7 write one no effect");
    wr(3'd4, 16'hFFFD);
    rd(3'd4, 16'h0000, "R7 write zero clears");
    pin = 16'h0002;
    ticks(3);
    wr(3'd4, 16'hFFFD);
    expect_val(1, 20'h00020, "R7 active level keeps bit");
    pin = 16'h0000;
    ticks(3);
    wr(3'd4, 16'h0000);
    expect_val(1, 20'h00000, "R7 clear after release");

    // R9 unmasked pin
    pin = 16'h0004;
    ticks(3);
    expect_val(1, 20'h00040, "R9 R8 unmasked no irq");
    expect_val(4, 20'h00000, "R9 unmasked no wake");
    pin = 16'h0000;
    ticks(3);

    // R8 R9 masked pin
    wr(3'd3, 16'h0004);
    pin = 16'h0004;
    ticks(2);
    expect_val(4, 20'h00000, "R9 wake not before third edge");
    ticks(1);
    expect_val(4, 20'h00001, "R9 wake pulse");
    expect_val(1, 20'h00041, "R8 irq flag set");
    ticks(1);
    expect_val(4, 20'h00000, "R9 wake single cycle");
    expect_val(1, 20'h00041, "R8 irq level held");
    pin = 16'h0000;
    ticks(2);
    expect_val(1, 20'h00000, "R8 irq cleared");

    ticks(2);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule